// File: doc/BRIEF.md
# Configuration Access Dispatcher

This block sits behind a host programmed-I/O port and steers configuration reads and writes to one of 256 device/function configuration targets. The host presents an address, a byte count and, for writes, data. The block takes the window base away from the address. It reads the slot index and the register offset out of the difference, and checks the byte count and the slot's populated flag. It then either drives a one-hot select with a shared register/size/data bus toward the targets, or answers the request itself.

A read of an empty slot returns all ones, sized to the access. A write to an empty slot and any request with an illegal byte count answer with an error flag, and neither touches a target. Each request gets exactly one response. The response arrives a fixed number of cycles after acceptance. That number is the programmed-I/O latency parameter times the bus clock ratio parameter. While a request is outstanding, the block refuses new ones.

Top module: `cfg_dispatch`

## Requirements
- R1: The block computes offset = req_addr - WIN_BASE. The slot index is offset[15:8], where offset[15:11] is the device and offset[10:8] is the function. The register offset is offset[7:0]. Slot index k drives tgt_sel[k] and reads slot_present[k]. An offset of 0x10000 or above is treated as an empty slot.
- R2: req_size gives the byte count. Only 1, 2 and 4 are legal. Any other value answers with rsp_err=1 and rsp_rdata=0, and raises no target strobe.
- R3: A legal read of an empty slot answers with all ones in the accessed width: 0xFF, 0xFFFF or 0xFFFFFFFF. It answers with rsp_err=0 and raises no strobe.
- R4: A legal read of a populated slot raises tgt_rd for one cycle, in the first cycle after acceptance, with that slot's tgt_sel bit and with tgt_reg and tgt_size. The response carries tgt_rdata.
- R5: A write to an empty slot answers with rsp_err=1 and raises no tgt_wr.
- R6: A legal write to a populated slot raises tgt_wr for one cycle, in the first cycle after acceptance, with tgt_sel, tgt_reg and tgt_size. tgt_wdata carries req_wdata with the bits above the byte count cleared. The response has rsp_err=0 and rsp_rdata=0.
- R7: rsp_valid is a one-cycle pulse. It comes LAT = PIO_LAT*CLK_RATIO rising edges after the accepting edge, counting the first edge after acceptance as edge 1.
- R8: req_ready is 1 when idle and 0 from the accepting edge through the response cycle. Requests presented while req_ready is 0 are ignored.
- R9: rsp_rdata bits above the accessed width are 0. rsp_rdata and rsp_err are 0 whenever rsp_valid is 0.
- R10: After reset, req_ready=1 and rsp_valid, tgt_rd, tgt_wr and tgt_sel are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_size | input | 3 | Access byte count |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data, zero-extended |
| rsp_err | output | 1 | Illegal size or write to empty slot |
| slot_present | input | 256 | Populated flag per slot index |
| tgt_sel | output | 256 | One-hot target select |
| tgt_rd | output | 1 | Read strobe |
| tgt_wr | output | 1 | Write strobe |
| tgt_reg | output | 8 | Register offset |
| tgt_size | output | 3 | Byte count to target |
| tgt_wdata | output | DATA_W | Masked write data |
| tgt_rdata | input | DATA_W | Data from the selected target |

## Verification
The response pulse of one request and the arrival of the next request can fall in the same cycle. In that cycle req_ready is still low. The bench holds req_valid high with a write to a populated slot from the first busy cycle through the response cycle of the shorter-latency instance. It then checks three things: that cycle carries the first request's correct read data, no write strobe ever appears, and no second response follows. Two instances with latencies of 2 and 6 run the same stimulus, so the exact response edge is checked at both settings.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;
    localparam int SIZE_W = 3;
    localparam logic [SIZE_W-1:0] SZ_B1 = 3'd1;
    localparam logic [SIZE_W-1:0] SZ_B2 = 3'd2;
    localparam logic [SIZE_W-1:0] SZ_B4 = 3'd4;
endpackage

// File: rtl/cfgd_decode.sv
module cfgd_decode
    import cfgd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = '0,
    parameter int SLOT_W = 8,
    parameter int REG_W  = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [SIZE_W-1:0]   size,
    input  logic                write,
    input  logic [(1<<SLOT_W)-1:0] present,
    output logic [SLOT_W-1:0]   slot,
    output logic [REG_W-1:0]    regoff,
    output logic                access,
    output logic                fill,
    output logic                err
);
    localparam int OFF_W = SLOT_W + REG_W;

    logic [ADDR_W-1:0] offset;
    logic in_win, legal, populated;

    always_comb begin
        offset    = addr - WIN_BASE;
        in_win    = (offset >> OFF_W) == '0;
        slot      = offset[REG_W +: SLOT_W];
        regoff    = offset[REG_W-1:0];
        legal     = (size == SZ_B1) || (size == SZ_B2) || (size == SZ_B4);
        populated = in_win && present[slot];
        access    = legal && populated;
        fill      = legal && !populated && !write;
        err       = !legal || (write && !populated);
    end
endmodule

// File: rtl/cfgd_onehot.sv
module cfgd_onehot #(
    parameter int SLOT_W = 8
) (
    input  logic                   en,
    input  logic [SLOT_W-1:0]      slot,
    output logic [(1<<SLOT_W)-1:0] sel
);
    for (genvar i = 0; i < (1 << SLOT_W); i++) begin : g_sel
        assign sel[i] = en && (slot == SLOT_W'(i));
    end
endmodule

// File: rtl/cfg_dispatch.sv
module cfg_dispatch
    import cfgd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0008_0000,
    parameter int DATA_W    = 32,
    parameter int DEV_W     = 5,
    parameter int FUNC_W    = 3,
    parameter int REG_W     = 8,
    parameter int PIO_LAT   = 1,
    parameter int CLK_RATIO = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    input  logic [(1<<(DEV_W+FUNC_W))-1:0] slot_present,
    output logic [(1<<(DEV_W+FUNC_W))-1:0] tgt_sel,
    output logic                tgt_rd,
    output logic                tgt_wr,
    output logic [REG_W-1:0]    tgt_reg,
    output logic [SIZE_W-1:0]   tgt_size,
    output logic [DATA_W-1:0]   tgt_wdata,
    input  logic [DATA_W-1:0]   tgt_rdata
);
    localparam int SLOT_W = DEV_W + FUNC_W;
    localparam int LAT    = PIO_LAT * CLK_RATIO;
    localparam int CNT_W  = (LAT > 1) ? $clog2(LAT) : 1;

    typedef struct packed {
        logic               busy;
        logic               first;
        logic [CNT_W-1:0]   cnt;
        logic               write;
        logic               access;
        logic               fill;
        logic               err;
        logic [SLOT_W-1:0]  slot;
        logic [REG_W-1:0]   regoff;
        logic [SIZE_W-1:0]  size;
        logic [DATA_W-1:0]  wdata;
    } state_t;

    state_t st_d, st_q;

    logic [SLOT_W-1:0] dec_slot;
    logic [REG_W-1:0]  dec_reg;
    logic              dec_access, dec_fill, dec_err;

    function automatic logic [DATA_W-1:0] width_mask(input logic [SIZE_W-1:0] sz);
        case (sz)
            SZ_B1:   width_mask = DATA_W'({8{1'b1}});
            SZ_B2:   width_mask = DATA_W'({16{1'b1}});
            SZ_B4:   width_mask = DATA_W'({32{1'b1}});
            default: width_mask = '0;
        endcase
    endfunction

    cfgd_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .SLOT_W(SLOT_W), .REG_W(REG_W)
    ) u_decode (
        .addr(req_addr), .size(req_size), .write(req_write),
        .present(slot_present), .slot(dec_slot), .regoff(dec_reg),
        .access(dec_access), .fill(dec_fill), .err(dec_err)
    );

    always_comb begin
        st_d       = st_q;
        st_d.first = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy   = 1'b0;
                st_d.access = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (req_valid) begin
            st_d.busy   = 1'b1;
            st_d.first  = 1'b1;
            st_d.cnt    = CNT_W'(LAT - 1);
            st_d.write  = req_write;
            st_d.access = dec_access;
            st_d.fill   = dec_fill;
            st_d.err    = dec_err;
            st_d.slot   = dec_slot;
            st_d.regoff = dec_reg;
            st_d.size   = req_size;
            st_d.wdata  = req_wdata & width_mask(req_size);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cfgd_onehot #(.SLOT_W(SLOT_W)) u_onehot (
        .en(st_q.busy && st_q.access), .slot(st_q.slot), .sel(tgt_sel)
    );

    always_comb begin
        req_ready = !st_q.busy;
        rsp_valid = st_q.busy && (st_q.cnt == '0);
        tgt_rd    = st_q.first && st_q.access && !st_q.write;
        tgt_wr    = st_q.first && st_q.access && st_q.write;
        tgt_reg   = st_q.regoff;
        tgt_size  = st_q.size;
        tgt_wdata = st_q.wdata;
        rsp_err   = rsp_valid && st_q.err;
        rsp_rdata = '0;
        if (rsp_valid) begin
            if (st_q.fill)
                rsp_rdata = width_mask(st_q.size);
            else if (st_q.access && !st_q.write)
                rsp_rdata = tgt_rdata & width_mask(st_q.size);
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel)); // R1
    AST_RD_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd |-> |(tgt_sel & slot_present)); // R4
    AST_WR_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |-> |(tgt_sel & slot_present)); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_rd && tgt_wr)); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0 && !rsp_err)); // R9
endmodule

// File: tb/cfg_dispatch_bench.sv
module cfg_dispatch_bench;
    localparam logic [31:0] BASE = 32'h0008_0000;
    localparam int LAT_A = 2;
    localparam int LAT_B = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [2:0]  req_size = '0;
    logic [255:0] present;

    logic a_ready, a_rsp, a_err, a_rd, a_wr;
    logic [31:0] a_rdata, a_wdata, a_trd;
    logic [255:0] a_sel;
    logic [7:0] a_reg;
    logic [2:0] a_size;
    logic b_ready, b_rsp, b_err, b_rd, b_wr;
    logic [31:0] b_rdata, b_wdata, b_trd;
    logic [255:0] b_sel;
    logic [7:0] b_reg;
    logic [2:0] b_size;

    int total = 0;
    int failed = 0;

    assign present = (256'd1 << 8'h00) | (256'd1 << 8'h2B) | (256'd1 << 8'hFF);

    function automatic logic [7:0] sel_index(input logic [255:0] s);
        sel_index = 8'h00;
        for (int i = 0; i < 256; i++) if (s[i]) sel_index = 8'(i);
    endfunction

    assign a_trd = {8'h5A, sel_index(a_sel), a_reg, 8'hC3};
    assign b_trd = {8'h5A, sel_index(b_sel), b_reg, 8'hC3};

    cfg_dispatch #(.WIN_BASE(BASE), .PIO_LAT(1), .CLK_RATIO(2)) u_cfg_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(a_rsp), .rsp_rdata(a_rdata),
        .rsp_err(a_err), .slot_present(present), .tgt_sel(a_sel),
        .tgt_rd(a_rd), .tgt_wr(a_wr), .tgt_reg(a_reg), .tgt_size(a_size),
        .tgt_wdata(a_wdata), .tgt_rdata(a_trd)
    );

    cfg_dispatch #(.WIN_BASE(BASE), .PIO_LAT(2), .CLK_RATIO(3)) u_cfg_dispatch_slow (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(b_rsp), .rsp_rdata(b_rdata),
        .rsp_err(b_err), .slot_present(present), .tgt_sel(b_sel),
        .tgt_rd(b_rd), .tgt_wr(b_wr), .tgt_reg(b_reg), .tgt_size(b_size),
        .tgt_wdata(b_wdata), .tgt_rdata(b_trd)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [2:0] sz);
        case (sz)
            3'd1: mask_of = 32'h0000_00FF;
            3'd2: mask_of = 32'h0000_FFFF;
            3'd4: mask_of = 32'hFFFF_FFFF;
            default: mask_of = 32'h0;
        endcase
    endfunction

    // One request, checked on both instances: strobes (R4/R6), timing (R7), data (R2/R3/R9)
    task automatic run_req(input string tag, input logic wr, input logic [31:0] addr,
                           input logic [2:0] sz, input logic [31:0] wd);
        logic [31:0] off = addr - BASE;
        logic legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
        logic pres = (off[31:16] == 16'h0) && present[off[15:8]];
        logic acc = legal && pres;
        logic exp_err = !legal || (wr && !pres);
        logic [31:0] exp_rd;
        if (!legal || wr) exp_rd = 32'h0;
        else if (!pres) exp_rd = mask_of(sz);
        else exp_rd = {8'h5A, off[15:8], off[7:0], 8'hC3} & mask_of(sz);

        @(negedge clk);
        check("R8", {tag, " ready before"}, {31'b0, a_ready & b_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(wr ? "R6" : "R4", {tag, " rd strobe"}, {31'b0, a_rd}, {31'b0, acc && !wr});
        check(wr ? "R6" : "R5", {tag, " wr strobe"}, {31'b0, a_wr}, {31'b0, acc && wr});
        check("R4", {tag, " slow strobes"}, {30'b0, b_rd, b_wr}, {30'b0, acc && !wr, acc && wr});
        if (acc) begin
            check("R1", {tag, " sel"}, {24'b0, sel_index(a_sel)}, {24'b0, off[15:8]});
            check("R1", {tag, " reg"}, {24'b0, a_reg}, {24'b0, off[7:0]});
            check("R4", {tag, " size"}, {29'b0, a_size}, {29'b0, sz});
            if (wr) check("R6", {tag, " wdata"}, a_wdata, wd & mask_of(sz));
        end else begin
            check("R2", {tag, " no select"}, {31'b0, |a_sel}, 32'd0);
        end
        for (int n = 1; n <= LAT_B + 1; n++) begin
            if (n > 1) @(negedge clk);
            check("R7", $sformatf("%s fast rsp n=%0d", tag, n), {31'b0, a_rsp}, {31'b0, n == LAT_A});
            check("R7", $sformatf("%s slow rsp n=%0d", tag, n), {31'b0, b_rsp}, {31'b0, n == LAT_B});
            if (n == LAT_A) begin
                check("R9", {tag, " fast rdata"}, a_rdata, exp_rd);
                check("R2", {tag, " fast err"}, {31'b0, a_err}, {31'b0, exp_err});
            end
            if (n == LAT_B) begin
                check("R9", {tag, " slow rdata"}, b_rdata, exp_rd);
                check("R5", {tag, " slow err"}, {31'b0, b_err}, {31'b0, exp_err});
            end
            if (n != LAT_A)
                check("R9", {tag, " idle quiet"}, {a_rdata[31:1], a_err}, 32'd0);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10", "ready", {31'b0, a_ready & b_ready}, 32'd1);
        check("R10", "rsp", {31'b0, a_rsp | b_rsp}, 32'd0);
        check("R10", "strobes", {30'b0, a_rd | b_rd, a_wr | b_wr}, 32'd0);
        check("R10", "sel", {31'b0, |a_sel | |b_sel}, 32'd0);
    endtask

    task automatic t_present_reads;
        run_req("R4 rd1", 1'b0, BASE + 32'h2B10, 3'd1, 32'h0);
        run_req("R4 rd2", 1'b0, BASE + 32'h0006, 3'd2, 32'h0);
        run_req("R4 rd4", 1'b0, BASE + 32'hFFFC, 3'd4, 32'h0);
    endtask

    task automatic t_absent_reads;
        run_req("R3 rd1", 1'b0, BASE + 32'h1200, 3'd1, 32'h0);
        run_req("R3 rd2", 1'b0, BASE + 32'h2C04, 3'd2, 32'h0);
        run_req("R3 rd4", 1'b0, BASE + 32'h0100, 3'd4, 32'h0);
        run_req("R1 outwin", 1'b0, BASE + 32'h0001_2B00, 3'd4, 32'h0);
    endtask

    task automatic t_writes;
        run_req("R6 wr1", 1'b1, BASE + 32'h2B3C, 3'd1, 32'hDEAD_BEEF);
        run_req("R6 wr2", 1'b1, BASE + 32'hFF02, 3'd2, 32'h1234_5678);
        run_req("R6 wr4", 1'b1, BASE + 32'h0040, 3'd4, 32'hCAFE_F00D);
        run_req("R5 wrabs", 1'b1, BASE + 32'h0700, 3'd4, 32'h1111_2222);
    endtask

    task automatic t_bad_size;
        run_req("R2 sz3 rd", 1'b0, BASE + 32'h2B00, 3'd3, 32'h0);
        run_req("R2 sz0 wr", 1'b1, BASE + 32'h0000, 3'd0, 32'hFFFF_FFFF);
        run_req("R2 sz7 abs", 1'b0, BASE + 32'h0900, 3'd7, 32'h0);
    endtask

    // R8: request held during busy, overlapping the fast instance's response cycle
    task automatic t_busy_ignore;
        int a_rsps = 0;
        int b_rsps = 0;
        int wrs = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = BASE + 32'h2B20; req_size = 3'd4;
        @(negedge clk);
        req_write = 1'b1; req_addr = BASE + 32'h0008; req_wdata = 32'hA5A5_A5A5;
        for (int n = 1; n <= LAT_B + 3; n++) begin
            if (n > 1) @(negedge clk);
            if (n <= LAT_A) check("R8", $sformatf("ready low n=%0d", n), {31'b0, a_ready}, 32'd0);
            if (n == LAT_A) begin
                check("R8", "rsp data with req pending", a_rdata, 32'h5A2B_20C3);
                req_valid = 1'b0;
            end
            a_rsps += int'(a_rsp);
            b_rsps += int'(b_rsp);
            wrs += int'(a_wr) + int'(b_wr);
        end
        check("R8", "fast response count", a_rsps, 1);
        check("R8", "slow response count", b_rsps, 1);
        check("R8", "no write strobe", wrs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_present_reads();
        t_absent_reads();
        t_writes();
        t_bad_size();
        t_busy_ignore();
        run_req("R7 after busy", 1'b0, BASE + 32'hFF00, 3'd2, 32'h0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule